// File: doc/BRIEF.md
# Test Single-Pulse Clock Generator

This block shapes one differential CPU clock output pair for a burn-in test mode. It runs on a reference clock and derives the CPU clock internally by dividing that clock. The CPU clock period is `2*HALF_CYC` reference cycles, with the high phase lasting `HALF_CYC` cycles. Two configuration bits drive it from a register domain that is not synchronous to the reference clock: a test-mode bit and a pulse-request bit. Both bits are brought into the reference domain through a synchronizer of `SYNC_STAGES` flops.

When test mode is off, the pair carries the free-running CPU clock. When test mode is on, the pair is parked in a differential-low state. Each new low-to-high change of the pulse-request bit then lets exactly one full CPU period through, aligned to the start of a period. After that one period the pair parks again. A request bit that simply stays high yields only the first pulse. Software must clear the bit before it can ask for another pulse.

Top module: `cpu_test_pulse_gen`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), the pair is driven with cpu_t = 0 and cpu_c = 1 from the following cycle on. Both configuration inputs are taken as 0 from reset.
- R2: cpu_c is always the inverse of cpu_t outside reset.
- R3: With test_mode at 0 and no pulse accepted, cpu_t toggles with a period of 2*HALF_CYC reference cycles. Each high run lasts exactly HALF_CYC cycles.
- R4: With test_mode at 1 and no pulse in flight, the pair stays parked at cpu_t = 0, cpu_c = 1.
- R5: With test_mode at 1, each 0-to-1 change of pulse_req produces exactly one rising edge on cpu_t. That high run lasts HALF_CYC cycles and is followed by the parked state. The emitted period begins at a CPU period boundary.
- R6: Holding pulse_req at 1 produces no further pulse. A new pulse needs pulse_req to return to 0 and rise again.
- R7: A 0-to-1 change of pulse_req while test_mode is 0 is ignored. It queues no pulse, even if test_mode is set afterwards while pulse_req stays high.
- R8: In test mode, the first rising edge of cpu_t follows the rise of pulse_req by at most SYNC_STAGES + 2*HALF_CYC + 2 reference clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the CPU clock is derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Test-mode configuration bit (asynchronous to clk) |
| pulse_req | input | 1 | Pulse-request configuration bit (asynchronous to clk) |
| cpu_t | output | 1 | True leg of the CPU clock pair |
| cpu_c | output | 1 | Complement leg of the CPU clock pair |

## Verification
The assertions assume that test_mode and pulse_req are quasi-static register bits. Each bit must hold a value for longer than the synchronizer depth plus one CPU period. Only under that assumption does a single low-to-high change appear as exactly one detected edge, and only then is the parked state visible between pulses. The stimulus changes these bits only on the falling edge of clk. It leaves at least 12 reference cycles of settling after each mode change and at least 16 cycles between request edges, well above the worst-case latency of 8 cycles at default parameters.

// File: rtl/tpg_pkg.sv
// Shared types and helpers for the test single-pulse clock generator.
// Assumes nothing beyond being compiled before the modules that import it.
package tpg_pkg;

    // Value of the differential pair: true leg and complement leg.
    typedef struct packed {
        logic tru;
        logic cmp;
    } diff_pair_t;

    // Build the pair from the true-leg level; the complement is its inverse.
    function automatic diff_pair_t pair_from(input logic level);
        diff_pair_t p;
        p.tru = level;
        p.cmp = ~level;
        return p;
    endfunction

endpackage

// File: rtl/tpg_sync.sv
// Multi-flop synchronizer for a bundle of quasi-static control bits.
// Assumes each bit is stable for several clock cycles (register-driven).
module tpg_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the bundle one stage further into the clk domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tpg_phase.sv
// CPU clock phase generator: divides the reference clock by 2*HALF_CYC.
// Assumes HALF_CYC >= 1. Counter restarts at 0 from reset.
module tpg_phase #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run_hi,
    output logic last
);
    localparam int PERIOD = 2 * HALF_CYC;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    // Advance the phase counter and wrap at the end of each CPU period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign run_hi = (cnt < CW'(HALF_CYC));
    assign last   = (cnt == CW'(PERIOD - 1));
endmodule

// File: rtl/tpg_pulse_ctl.sv
// Pulse controller: detects request rises in test mode, holds them pending
// and opens an emit window of exactly one CPU period at a period boundary.
// Assumes synchronized inputs and a last-cycle marker from the phase counter.
module tpg_pulse_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_s,
    input  logic trig_s,
    input  logic last,
    output logic trig_rise,
    output logic pending,
    output logic emitting
);
    logic trig_d;
    logic accept;

    assign trig_rise = trig_s & ~trig_d;
    assign accept    = trig_rise & mode_s;

    // Remember the previous request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig_s;
    end

    // Move pending requests into the emit window at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            emitting <= 1'b0;
        end else if (last) begin
            emitting <= pending;
            pending  <= accept;
        end else if (accept) begin
            pending  <= 1'b1;
        end
    end
endmodule

// File: rtl/cpu_test_pulse_gen.sv
// Test single-pulse clock generator, top level.
// Passes the divided CPU clock in normal mode; parks the pair low in test
// mode and releases one full period per request rise. Assumes test_mode and
// pulse_req are slow register bits from another clock domain.
module cpu_test_pulse_gen #(
    parameter int HALF_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic pulse_req,
    output logic cpu_t,
    output logic cpu_c
);
    import tpg_pkg::*;

    logic [1:0] cfg_s;
    logic       mode_s;
    logic       trig_s;
    logic       run_hi;
    logic       last;
    logic       trig_rise;
    logic       pending;
    logic       emitting;
    logic       drive;
    diff_pair_t pair_q;

    tpg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({test_mode, pulse_req}),
        .q_sync  (cfg_s)
    );

    assign mode_s = cfg_s[1];
    assign trig_s = cfg_s[0];

    tpg_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_hi (run_hi),
        .last   (last)
    );

    tpg_pulse_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (mode_s),
        .trig_s    (trig_s),
        .last      (last),
        .trig_rise (trig_rise),
        .pending   (pending),
        .emitting  (emitting)
    );

    // The clock passes while in normal mode with nothing pending, or in a pulse.
    assign drive = (~mode_s & ~pending) | emitting;

    // Register the pair so both legs switch glitch-free from one flop stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= pair_from(1'b0);
        else        pair_q <= pair_from(drive & run_hi);
    end

    assign cpu_t = pair_q.tru;
    assign cpu_c = pair_q.cmp;
endmodule

// File: rtl/tpg_checker.sv
// Assertion checker for cpu_test_pulse_gen, attached by bind.
// Assumes the internal synchronized mode, pending and emit state are visible.
module tpg_checker #(
    parameter int HALF_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_t,
    input logic cpu_c,
    input logic mode_s,
    input logic pending,
    input logic emitting,
    input logic trig_rise,
    input logic last
);
    localparam int RW = $clog2(2 * HALF_CYC + 2) + 2;

    logic [RW-1:0] hi_run;

    // Count consecutive high cycles on the true leg.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_run <= '0;
        else if (cpu_t) hi_run <= hi_run + 1'b1;
        else            hi_run <= '0;
    end

    // R1
    reset_park_chk: assert property (@(posedge clk)
        !rst_n |=> (!cpu_t && cpu_c));

    // R4
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !pending && !emitting) |=> (!cpu_t && cpu_c));

    // R5
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RW'(HALF_CYC));

    // R5
    emit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emitting) |-> $past(last));

    // R7
    ignore_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && !pending && trig_rise) |=> !pending);
endmodule

bind cpu_test_pulse_gen tpg_checker #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_t     (cpu_t),
    .cpu_c     (cpu_c),
    .mode_s    (mode_s),
    .pending   (pending),
    .emitting  (emitting),
    .trig_rise (trig_rise),
    .last      (last)
);

// File: tb/cpu_test_pulse_gen_bench.sv
module cpu_test_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int SYNC       = 2;
    localparam int LAT_MAX    = SYNC + 2 * HALF + 2;

    // Vector: [8:5] expected rises, [4] mode, [3:0] request edges
    localparam logic [8:0] VEC [0:5] = '{
        {4'd10, 1'b0, 4'd0},
        {4'd0,  1'b1, 4'd0},
        {4'd1,  1'b1, 4'd1},
        {4'd3,  1'b1, 4'd3},
        {4'd10, 1'b0, 4'd0},
        {4'd2,  1'b1, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic pulse_req = 1'b0;
    logic cpu_t, cpu_c;

    int checks = 0;
    int failures = 0;
    int rises, bad_runs, mism, run_len;
    logic prev_t = 1'b0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_test_pulse_gen #(.HALF_CYC(HALF), .SYNC_STAGES(SYNC)) u_cpu_test_pulse_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .pulse_req (pulse_req),
        .cpu_t     (cpu_t),
        .cpu_c     (cpu_c)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        rises = 0; bad_runs = 0; mism = 0;
    endtask

    // Sample the pair on falling edges for n cycles, accumulating statistics.
    task automatic observe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_c !== ~cpu_t) mism++;
            if (cpu_t && !prev_t) rises++;
            if (cpu_t) run_len++;
            else begin
                if (prev_t && run_len != HALF) bad_runs++;
                run_len = 0;
            end
            prev_t = cpu_t;
        end
    endtask

    initial begin
        run_len = 0;
        clear_counts();
        repeat (3) @(negedge clk);
        // R1: pair parked during reset
        check(cpu_t == 1'b0 && cpu_c == 1'b1, "R1 reset pair", {cpu_t, cpu_c}, 2'b01);
        rst_n = 1'b1;
        observe(12);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            test_mode = VEC[v][4];
            observe(12);
            clear_counts();
            if (VEC[v][3:0] == 0) observe(40);
            for (int e = 0; e < int'(VEC[v][3:0]); e++) begin
                pulse_req = 1'b1;
                observe(16);
                pulse_req = 1'b0;
                observe(16);
            end
            if (VEC[v][4])
                check(rises == int'(VEC[v][8:5]), "R5 R4 pulse count in test mode", rises, VEC[v][8:5]);
            else
                check(rises == int'(VEC[v][8:5]), "R3 normal clock rises", rises, VEC[v][8:5]);
            check(bad_runs == 0, "R3 R5 high run width", bad_runs, 0);
            check(mism == 0, "R2 complement legs", mism, 0);
        end

        // R6: held request gives one pulse only
        test_mode = 1'b1;
        observe(12);
        clear_counts();
        pulse_req = 1'b1;
        observe(40);
        check(rises == 1, "R6 first pulse of held request", rises, 1);
        clear_counts();
        observe(40);
        check(rises == 0, "R6 no repeat while held", rises, 0);
        pulse_req = 1'b0;
        observe(16);

        // R7: edge while mode clear is ignored
        test_mode = 1'b0;
        observe(12);
        pulse_req = 1'b1;
        observe(12);
        test_mode = 1'b1;
        observe(12);
        clear_counts();
        observe(40);
        check(rises == 0, "R7 ignored request edge", rises, 0);
        pulse_req = 1'b0;
        observe(16);

        // R8: latency from request to first rise
        begin
            int lat;
            lat = 0;
            pulse_req = 1'b1;
            while (lat < 30) begin
                @(negedge clk);
                lat++;
                if (cpu_t) break;
            end
            prev_t = cpu_t;
            run_len = cpu_t ? 1 : 0;
            check(lat <= LAT_MAX, "R8 pulse latency", lat, LAT_MAX);
            observe(16);
            pulse_req = 1'b0;
            observe(16);
        end

        // R1: reset in the middle of normal running
        test_mode = 1'b0;
        observe(20);
        rst_n = 1'b0;
        @(negedge clk);
        check(cpu_t == 1'b0 && cpu_c == 1'b1, "R1 mid-run reset pair", {cpu_t, cpu_c}, 2'b01);
        @(negedge clk);
        check(cpu_t == 1'b0 && cpu_c == 1'b1, "R1 reset held pair", {cpu_t, cpu_c}, 2'b01);
        rst_n = 1'b1;
        prev_t = 1'b0;
        run_len = 0;
        observe(12);
        clear_counts();
        observe(40);
        check(rises == 10, "R3 clock after reset", rises, 10);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule